// File: doc/BRIEF.md
# Thread-Aware Branch Prediction Front End

This block predicts the next fetch address for a core that interleaves several hardware threads. Every lookup and every training update carries the number of the thread it belongs to. Each structure is shared in its own way. The target buffer is shared, but each of its entries records which thread wrote it. The pattern counters are shared with no owner at all. The branch history and the return stack are private copies, one per thread.

A lookup is combinational. It reads only registered state, so an update presented in the same cycle becomes visible from the next cycle on. An update reports a branch that has resolved. It gives the branch's address, kind, outcome and target. Each structure then trains only the state that belongs to that branch's thread, or the shared state where sharing is intended.

Top module: `tbp_frontend`

## Requirements
- R1: After reset, and whenever `lk_valid` is low, `pr_hit` and `pr_taken` are 0. After reset every target-buffer entry is empty, so a valid lookup returns `pr_target` = `lk_pc`+4. Every pattern counter resets to 1 (weakly not taken).
- R2: A target-buffer entry is selected by `pc[BTB_IDX_W+1:2]`. It is written only when an update has `up_taken`=1, and it stores the tag, the thread, the target and the kind. A later lookup by the same thread at the same PC hits.
- R3: An entry whose stored thread differs from `lk_tid` is a miss: `pr_hit`=0, `pr_taken`=0 and `pr_target`=`lk_pc`+4.
- R4: Replacing an entry rewrites both its tag and its thread. The previous owner then misses at its PC, and so does a PC with the old tag.
- R5: The counter index is the thread's history XOR `pc[DIR_IDX_W+1:2]`. Counters are 2-bit and saturate at 0 and 3. A conditional hit predicts taken when the counter is 2 or more, and `pr_target` is `lk_pc`+4 when it predicts not taken.
- R6: The counters carry no thread: training by one thread changes the prediction another thread gets at the same index.
- R7: Each thread has its own history register. A conditional update shifts its outcome into bit 0 of the issuing thread's history only.
- R8: A call update pushes its PC+4 onto the issuing thread's return stack. A return hit predicts taken with the top of that thread's stack as target, and a return update pops it.
- R9: The return stacks are private: pushes and pops by one thread never change another thread's return predictions.
- R10: A push onto a full stack (depth 2^RAS_AW) overwrites the oldest entry. A pop on an empty stack has no effect. A return hit with an empty stack predicts the target stored in the target buffer.
- R11: `up_kind` encodes 0 = conditional, 1 = call, 2 = return, 3 = jump. A jump or call hit predicts taken with the stored target.
- R12: A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_tid | input | TID_W | Thread of the lookup |
| lk_pc | input | PC_W | Address being fetched |
| up_valid | input | 1 | Resolved-branch update |
| up_tid | input | TID_W | Thread owning the resolved branch |
| up_pc | input | PC_W | Address of the resolved branch |
| up_kind | input | 2 | Branch kind (0 cond, 1 call, 2 return, 3 jump) |
| up_taken | input | 1 | Resolved outcome |
| up_target | input | PC_W | Resolved target |
| pr_hit | output | 1 | Target-buffer hit for this thread |
| pr_taken | output | 1 | Predicted taken |
| pr_target | output | PC_W | Predicted next fetch address |

## Verification
The bench uses the defaults: two threads, an 8-entry target buffer, 4-bit history over 16 counters, and 4-deep return stacks. With these sizes PCs a few words apart collide in the target buffer and in the counters. One thread's history can therefore steer the other thread onto a counter it has just trained. Four calls are enough to fill a stack, and a fifth overwrites the oldest entry. The history reaches all-zero after a short run of not-taken outcomes, which lets the bench drive a single counter into its lower limit.

// File: rtl/tbp_pkg.sv
`timescale 1ns/1ps
package tbp_pkg;
  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_CALL = 2'd1,
    BK_RET  = 2'd2,
    BK_JUMP = 2'd3
  } br_kind_e;

  localparam logic [1:0] CTR_INIT = 2'b01;

  // saturating 2-bit counter step
  function automatic logic [1:0] ctr_next(input logic [1:0] c, input logic tk);
    if (tk) return (c == 2'b11) ? c : c + 2'd1;
    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/tbp_btb.sv
`timescale 1ns/1ps
module tbp_btb #(
  parameter int PC_W  = 32,
  parameter int TID_W = 1,
  parameter int IDX_W = 3,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [TID_W-1:0] rd_tid,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  output logic [1:0]       rd_kind,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TID_W-1:0] wr_tid,
  input  logic [PC_W-1:0]  wr_target,
  input  logic [1:0]       wr_kind
);
  localparam int ENTRIES = 1 << IDX_W;

  logic             vld_q  [ENTRIES];
  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [TID_W-1:0] tid_q  [ENTRIES];
  logic [PC_W-1:0]  tgt_q  [ENTRIES];
  logic [1:0]       kind_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  // replacement always rewrites owner together with tag
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      tid_q[wr_idx]  <= wr_tid;
      tgt_q[wr_idx]  <= wr_target;
      kind_q[wr_idx] <= wr_kind;
    end
  end

  logic tag_match, tid_match;
  always_comb begin
    tag_match = (tag_q[rd_idx] == rd_tag);
    tid_match = (tid_q[rd_idx] == rd_tid);
    rd_hit    = vld_q[rd_idx] && tag_match && tid_match;
    rd_target = tgt_q[rd_idx];
    rd_kind   = kind_q[rd_idx];
  end

  p_alloc_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)] && tid_q[$past(wr_idx)] == $past(wr_tid)
              && tag_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/tbp_dirtab.sv
`timescale 1ns/1ps
module tbp_dirtab #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken
);
  import tbp_pkg::*;
  localparam int ENTRIES = 1 << IDX_W;

  logic [1:0] tab_q [ENTRIES];
  logic [1:0] upd_cur;

  assign upd_cur = tab_q[upd_idx];
  assign rd_ctr  = tab_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab_q[i] <= CTR_INIT;
    end else if (upd_en) begin
      tab_q[upd_idx] <= ctr_next(upd_cur, upd_taken);
    end
  end

  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_taken && upd_cur == 2'b11) |=> tab_q[$past(upd_idx)] == 2'b11);
  p_sat_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken && upd_cur == 2'b00) |=> tab_q[$past(upd_idx)] == 2'b00);
endmodule

// File: rtl/tbp_ras.sv
`timescale 1ns/1ps
module tbp_ras #(
  parameter int PC_W = 32,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_val,
  output logic [PC_W-1:0] top_val,
  output logic            nonempty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [PC_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]   sp_q;   // next free slot, wraps
  logic [AW:0]     cnt_q;

  assign top_val  = mem_q[sp_q - AW'(1)];
  assign nonempty = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (push) mem_q[sp_q] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else if (push) begin
      sp_q  <= sp_q + AW'(1);
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end else if (pop && nonempty) begin
      sp_q  <= sp_q - AW'(1);
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_push_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_val == $past(push_val) && nonempty);
  p_full_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && cnt_q == FULL) |=> cnt_q == FULL);
  p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !nonempty) |=> $stable(sp_q) && !nonempty);
endmodule

// File: rtl/tbp_frontend.sv
`timescale 1ns/1ps
module tbp_frontend #(
  parameter int NTHR      = 2,
  parameter int PC_W      = 32,
  parameter int BTB_IDX_W = 3,
  parameter int DIR_IDX_W = 4,
  parameter int RAS_AW    = 2,
  parameter int TID_W     = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             up_valid,
  input  logic [TID_W-1:0] up_tid,
  input  logic [PC_W-1:0]  up_pc,
  input  logic [1:0]       up_kind,
  input  logic             up_taken,
  input  logic [PC_W-1:0]  up_target,
  output logic             pr_hit,
  output logic             pr_taken,
  output logic [PC_W-1:0]  pr_target
);
  import tbp_pkg::*;
  localparam int TAG_W = PC_W - BTB_IDX_W - 2;

  function automatic logic [BTB_IDX_W-1:0] btb_idx(input logic [PC_W-1:0] pc);
    return pc[BTB_IDX_W+1:2];
  endfunction
  function automatic logic [TAG_W-1:0] btb_tag(input logic [PC_W-1:0] pc);
    return pc[PC_W-1:BTB_IDX_W+2];
  endfunction
  function automatic logic [DIR_IDX_W-1:0] dir_idx(input logic [DIR_IDX_W-1:0] h,
                                                   input logic [PC_W-1:0] pc);
    return h ^ pc[DIR_IDX_W+1:2];
  endfunction

  // named update events
  br_kind_e up_k;
  logic     ev_cond, ev_call, ev_ret, ev_alloc;
  assign up_k     = br_kind_e'(up_kind);
  assign ev_cond  = up_valid && (up_k == BK_COND);
  assign ev_call  = up_valid && (up_k == BK_CALL);
  assign ev_ret   = up_valid && (up_k == BK_RET);
  assign ev_alloc = up_valid && up_taken;

  // per-thread history
  logic [DIR_IDX_W-1:0] hist_q [NTHR];
  logic [NTHR-1:0]      hist_upd;
  logic [PC_W-1:0]      ras_top [NTHR];
  logic [NTHR-1:0]      ras_ne;
  logic [PC_W-1:0]      ret_addr;
  assign ret_addr = up_pc + PC_W'(4);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign hist_upd[t] = ev_cond && (up_tid == TID_W'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[t] <= '0;
      else if (hist_upd[t]) hist_q[t] <= {hist_q[t][DIR_IDX_W-2:0], up_taken};
    end

    tbp_ras #(.PC_W(PC_W), .AW(RAS_AW)) i_ras (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ev_call && (up_tid == TID_W'(t))),
      .pop      (ev_ret  && (up_tid == TID_W'(t))),
      .push_val (ret_addr),
      .top_val  (ras_top[t]),
      .nonempty (ras_ne[t])
    );

    p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hist_upd[t] |=> hist_q[t][0] == $past(up_taken));
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hist_upd[t] |=> $stable(hist_q[t]));
  end

  // target buffer
  logic            btb_hit;
  logic [PC_W-1:0] btb_tgt;
  logic [1:0]      btb_kind;

  tbp_btb #(.PC_W(PC_W), .TID_W(TID_W), .IDX_W(BTB_IDX_W), .TAG_W(TAG_W)) i_btb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (btb_idx(lk_pc)),
    .rd_tag    (btb_tag(lk_pc)),
    .rd_tid    (lk_tid),
    .rd_hit    (btb_hit),
    .rd_target (btb_tgt),
    .rd_kind   (btb_kind),
    .wr_en     (ev_alloc),
    .wr_idx    (btb_idx(up_pc)),
    .wr_tag    (btb_tag(up_pc)),
    .wr_tid    (up_tid),
    .wr_target (up_target),
    .wr_kind   (up_kind)
  );

  // shared direction counters
  logic [1:0] dir_ctr;

  tbp_dirtab #(.IDX_W(DIR_IDX_W)) i_dir (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (dir_idx(hist_q[lk_tid], lk_pc)),
    .rd_ctr    (dir_ctr),
    .upd_en    (ev_cond),
    .upd_idx   (dir_idx(hist_q[up_tid], up_pc)),
    .upd_taken (up_taken)
  );

  // prediction
  logic            sel_tk;
  logic [PC_W-1:0] sel_tgt;
  always_comb begin
    sel_tk  = 1'b0;
    sel_tgt = btb_tgt;
    if (lk_valid && btb_hit) begin
      unique case (br_kind_e'(btb_kind))
        BK_COND: sel_tk = dir_ctr[1];
        BK_RET: begin
          sel_tk = 1'b1;
          if (ras_ne[lk_tid]) sel_tgt = ras_top[lk_tid];
        end
        default: sel_tk = 1'b1;
      endcase
    end
  end

  assign pr_hit    = lk_valid && btb_hit;
  assign pr_taken  = sel_tk;
  assign pr_target = sel_tk ? sel_tgt : lk_pc + PC_W'(4);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !pr_hit && !pr_taken);
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pr_taken |-> pr_hit);
endmodule

// File: tb/test_tbp_frontend.sv
`timescale 1ns/1ps
module test_tbp_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [0:0]  lk_tid = '0;
  logic [31:0] lk_pc = '0;
  logic        up_valid = 1'b0;
  logic [0:0]  up_tid = '0;
  logic [31:0] up_pc = '0;
  logic [1:0]  up_kind = '0;
  logic        up_taken = 1'b0;
  logic [31:0] up_target = '0;
  logic        pr_hit, pr_taken;
  logic [31:0] pr_target;

  always #2 clk = ~clk;

  tbp_frontend i_tbp_frontend (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_tid(lk_tid), .lk_pc(lk_pc),
    .up_valid(up_valid), .up_tid(up_tid), .up_pc(up_pc), .up_kind(up_kind),
    .up_taken(up_taken), .up_target(up_target),
    .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target)
  );

  typedef struct {
    logic        hit;
    logic        tk;
    logic [31:0] tgt;
    string       rq;
  } exp_t;

  exp_t  sb[$];
  exp_t  cur;
  int    total = 0;
  int    bad = 0;
  bit    done = 0;

  localparam logic [1:0] K_COND = 2'd0, K_CALL = 2'd1, K_RET = 2'd2, K_JUMP = 2'd3;

  // monitor: one scoreboard item per valid lookup cycle
  always @(negedge clk) begin
    if (rst_n && lk_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL lookup with empty scoreboard: hit=%0b tk=%0b tgt=%h", pr_hit, pr_taken, pr_target);
      end else begin
        cur = sb.pop_front();
        if (pr_hit !== cur.hit || pr_taken !== cur.tk || pr_target !== cur.tgt) begin
          bad++;
          $display("FAIL %s: actual hit=%0b tk=%0b tgt=%h expected hit=%0b tk=%0b tgt=%h",
                   cur.rq, pr_hit, pr_taken, pr_target, cur.hit, cur.tk, cur.tgt);
        end
      end
    end
  end

  task automatic look(input logic t, input logic [31:0] pc, input logic eh, input logic et,
                      input logic [31:0] etgt, input string rq);
    @(posedge clk); #1;
    up_valid = 1'b0;
    lk_valid = 1'b1; lk_tid = t; lk_pc = pc;
    sb.push_back('{hit: eh, tk: et, tgt: etgt, rq: rq});
  endtask

  task automatic upd(input logic t, input logic [31:0] pc, input logic [1:0] k,
                     input logic tk, input logic [31:0] tgt);
    @(posedge clk); #1;
    lk_valid = 1'b0;
    up_valid = 1'b1; up_tid = t; up_pc = pc; up_kind = k; up_taken = tk; up_target = tgt;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    lk_valid = 1'b0; up_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    look(0, 32'h100, 0, 0, 32'h104, "R1 reset miss");
    look(1, 32'h100, 0, 0, 32'h104, "R1 reset miss t1");

    // R2 / R11: jump allocates, same thread hits
    upd(0, 32'h200, K_JUMP, 1, 32'h400);
    look(0, 32'h200, 1, 1, 32'h400, "R2 R11 jump hit");
    // R3: other thread misses
    look(1, 32'h200, 0, 0, 32'h204, "R3 foreign entry");
    // R1: invalid lookup at a trained pc
    idle();
    lk_pc = 32'h200;
    #2;
    total++;
    if (pr_hit !== 1'b0 || pr_taken !== 1'b0) begin
      bad++;
      $display("FAIL R1 idle lookup: actual hit=%0b tk=%0b expected 0 0", pr_hit, pr_taken);
    end

    // R4: replacement by other thread, then by other tag
    upd(1, 32'h200, K_JUMP, 1, 32'h500);
    look(1, 32'h200, 1, 1, 32'h500, "R4 new owner");
    look(0, 32'h200, 0, 0, 32'h204, "R4 old owner");
    upd(0, 32'h220, K_JUMP, 1, 32'h600);
    look(1, 32'h200, 0, 0, 32'h204, "R4 old tag");
    look(0, 32'h220, 1, 1, 32'h600, "R4 new tag");

    // R12: same-cycle lookup sees old state
    @(posedge clk); #1;
    up_valid = 1'b1; up_tid = 0; up_pc = 32'h40; up_kind = K_JUMP; up_taken = 1; up_target = 32'h800;
    lk_valid = 1'b1; lk_tid = 0; lk_pc = 32'h40;
    sb.push_back('{hit: 1'b0, tk: 1'b0, tgt: 32'h44, rq: "R12 pre-update"});
    look(0, 32'h40, 1, 1, 32'h800, "R12 post-update");

    // R5 / R7: t0 cond taken at 0x300, counter[0] 1->2, hist0 = 0001
    upd(0, 32'h300, K_COND, 1, 32'h340);
    look(0, 32'h300, 1, 0, 32'h304, "R7 history shifted");
    // R6: t1 trains counter[1] (hist1=0 ^ 1), hist1 = 0001
    upd(1, 32'h304, K_COND, 1, 32'h380);
    look(0, 32'h300, 1, 1, 32'h340, "R6 shared counter");
    look(1, 32'h304, 1, 1, 32'h380, "R7 private history t1");
    // R5: drive counter[0] to bottom with not-taken runs on t0
    for (int i = 0; i < 7; i++) upd(0, 32'h300, K_COND, 0, 32'h340);
    look(0, 32'h300, 1, 0, 32'h304, "R5 saturate low");
    look(1, 32'h304, 1, 0, 32'h308, "R6 alias after t0 training");

    // R10: return on empty stack falls back, pop has no effect
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h9990, "R10 empty return");
    // R8: five calls on t0, depth 4
    for (int i = 0; i < 5; i++) upd(0, 32'h1000 + 32'(i) * 32'h100, K_CALL, 1, 32'h2000);
    look(0, 32'h2010, 1, 1, 32'h1404, "R8 return top");
    // R9: t1 stack is still empty
    upd(1, 32'h2014, K_RET, 1, 32'h7770);
    look(1, 32'h2014, 1, 1, 32'h7770, "R9 t1 empty");
    upd(1, 32'h3000, K_CALL, 1, 32'h4000);
    look(1, 32'h2014, 1, 1, 32'h3004, "R9 t1 own push");
    look(0, 32'h2010, 1, 1, 32'h1404, "R9 t0 untouched");
    // R10: pop down, oldest was overwritten
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h1304, "R8 pop 1");
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h1204, "R8 pop 2");
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h1104, "R10 last surviving");
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h9990, "R10 wrapped oldest gone");
    upd(0, 32'h2010, K_RET, 1, 32'h9990);
    look(0, 32'h2010, 1, 1, 32'h9990, "R10 pop on empty");
    upd(0, 32'h1500, K_CALL, 1, 32'h2000);
    look(0, 32'h2010, 1, 1, 32'h1504, "R10 push after empty pop");
    look(1, 32'h2014, 1, 1, 32'h3004, "R9 t1 after t0 pops");

    idle();
    idle();
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule